// File: doc/BRIEF.md
# Level-2 Cache Interrupt Status Unit

This block gathers single-cycle error and event pulses raised inside a level-2 cache controller and keeps them as sticky raw status bits. Software enables individual sources through a mask, reads back both the raw bits and their masked view, and acknowledges sources by writing ones to a clear register. Every source drives its own interrupt line from its masked bit, and one combined line is raised whenever any of those lines is high.

Nine sources are tracked: the event counter, parity errors on tag and data RAM reads, errors on tag and data RAM writes and reads, and slave errors and decode errors from the downstream memory port. A decode error from the downstream port is filed under the slave-error bit, so the decode-error bit is never set by hardware. Access is through a plain 32-bit register strobe port addressed by byte offset. Register reads return data one cycle after the strobe.

Top module: `l2_irq_unit`

## Requirements
- R1: After reset the raw status and mask registers are zero, every per-source line and the combined line are low, and the read data output is zero.
- R2: Status, mask and clear registers share one bit layout: bit 0 event counter, bit 1 tag read parity, bit 2 data read parity, bit 3 tag write error, bit 4 data write error, bit 5 tag read error, bit 6 data read error, bit 7 slave error, bit 8 decode error. Offsets: mask 0x214 (read/write), masked status 0x218, raw status 0x21C, clear 0x220 (write-only).
- R3: A source pulse sampled at a clock edge sets its raw status bit at that edge; the bit then stays set until cleared.
- R4: A write to the clear offset clears exactly the raw bits written as 1 at that edge; bits written as 0 are left unchanged.
- R5: When a source pulse and a clear of the same bit occur in the same cycle, the bit ends set.
- R6: A downstream decode-error pulse sets raw bit 7 (slave error); raw bit 8 stays zero.
- R7: The mask register is read/write over bits 8:0; masked status equals raw status AND mask, and each per-source line equals its masked status bit.
- R8: The combined interrupt line is high exactly when at least one per-source line is high.
- R9: Writes to the raw and masked status offsets and to unmapped offsets change nothing; reads of the clear offset and of unmapped offsets return zero; bits 31:9 of every register read as zero.
- R10: A read strobe at a clock edge presents the register value held before that edge on the read data output after the edge; the output holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ev_cnt_pls | input | 1 | Event counter pulse |
| tag_rd_par_pls | input | 1 | Tag RAM read parity error pulse |
| dat_rd_par_pls | input | 1 | Data RAM read parity error pulse |
| tag_wr_err_pls | input | 1 | Tag RAM write error pulse |
| dat_wr_err_pls | input | 1 | Data RAM write error pulse |
| tag_rd_err_pls | input | 1 | Tag RAM read error pulse |
| dat_rd_err_pls | input | 1 | Data RAM read error pulse |
| mem_slverr_pls | input | 1 | Slave error response from downstream port |
| mem_decerr_pls | input | 1 | Decode error response from downstream port |
| irq_line | output | 9 | Per-source interrupt lines, same bit layout as status |
| irq_any | output | 1 | Combined interrupt line |

## Verification
Source pulses and register writes both act at the edge that samples them, so raw status, the per-source lines and the combined line are due one edge after the stimulus, and a read strobe's data is due on the read data output after that same edge. The bench drives each cycle's inputs just after a rising edge, advances its own model of raw and mask at the next rising edge, and compares outputs one time unit later. Read data is predicted from the model state held before the edge, which covers same-cycle pulses, clears and reads together.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
    localparam int SRC_N  = 9;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam int B_EVCNT   = 0;
    localparam int B_TAG_PAR = 1;
    localparam int B_DAT_PAR = 2;
    localparam int B_TAG_WR  = 3;
    localparam int B_DAT_WR  = 4;
    localparam int B_TAG_RD  = 5;
    localparam int B_DAT_RD  = 6;
    localparam int B_SLVERR  = 7;
    localparam int B_DECERR  = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h214;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 12'h218;
    localparam logic [ADDR_W-1:0] OFS_RSTAT = 12'h21C;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h220;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_MASK,
        REG_MSTAT,
        REG_RSTAT,
        REG_CLEAR
    } reg_id_e;
endpackage

// File: rtl/l2irq_src_map.sv
module l2irq_src_map
    import l2irq_pkg::*;
(
    input  logic             ev_cnt_pls,
    input  logic             tag_rd_par_pls,
    input  logic             dat_rd_par_pls,
    input  logic             tag_wr_err_pls,
    input  logic             dat_wr_err_pls,
    input  logic             tag_rd_err_pls,
    input  logic             dat_rd_err_pls,
    input  logic             mem_slverr_pls,
    input  logic             mem_decerr_pls,
    output logic [SRC_N-1:0] set_vec
);
    always_comb begin
        set_vec            = '0;
        set_vec[B_EVCNT]   = ev_cnt_pls;
        set_vec[B_TAG_PAR] = tag_rd_par_pls;
        set_vec[B_DAT_PAR] = dat_rd_par_pls;
        set_vec[B_TAG_WR]  = tag_wr_err_pls;
        set_vec[B_DAT_WR]  = dat_wr_err_pls;
        set_vec[B_TAG_RD]  = tag_rd_err_pls;
        set_vec[B_DAT_RD]  = dat_rd_err_pls;
        // downstream decode errors are filed as slave errors
        set_vec[B_SLVERR]  = mem_slverr_pls | mem_decerr_pls;
        set_vec[B_DECERR]  = 1'b0;
    end
endmodule

// File: rtl/l2irq_stat_bit.sv
module l2irq_stat_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic raw_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     raw_o <= 1'b0;
        else if (set_i) raw_o <= 1'b1;
        else if (clr_i) raw_o <= 1'b0;
    end

    // R5: a pulse beats a same-cycle clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> raw_o);
    // R4: a clear without a pulse drops the bit
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !raw_o);
    // R3: with neither, the bit holds
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(raw_o));
endmodule

// File: rtl/l2irq_regport.sv
module l2irq_regport
    import l2irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [SRC_N-1:0]  raw_i,
    input  logic [SRC_N-1:0]  mstat_i,
    output logic [SRC_N-1:0]  mask_o,
    output logic [SRC_N-1:0]  clr_o,
    output logic [DATA_W-1:0] reg_rdata
);
    reg_id_e             reg_id;
    logic                wr_en;
    logic                rd_en;
    logic [SRC_N-1:0]    rd_val;
    logic [DATA_W-1:0]   rd_word;
    logic [DATA_W-SRC_N-1:0] unused_wdata_hi;

    assign unused_wdata_hi = reg_wdata[DATA_W-1:SRC_N];
    assign wr_en = reg_sel &  reg_wr;
    assign rd_en = reg_sel & ~reg_wr;

    always_comb begin
        unique case (reg_addr)
            OFS_MASK:  reg_id = REG_MASK;
            OFS_MSTAT: reg_id = REG_MSTAT;
            OFS_RSTAT: reg_id = REG_RSTAT;
            OFS_CLEAR: reg_id = REG_CLEAR;
            default:   reg_id = REG_NONE;
        endcase
    end

    always_comb begin
        unique case (reg_id)
            REG_MASK:  rd_val = mask_o;
            REG_MSTAT: rd_val = mstat_i;
            REG_RSTAT: rd_val = raw_i;
            default:   rd_val = '0;
        endcase
        rd_word = {{(DATA_W-SRC_N){1'b0}}, rd_val};
    end

    assign clr_o = (wr_en && reg_id == REG_CLEAR) ? reg_wdata[SRC_N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mask_o <= '0;
        else if (wr_en && reg_id == REG_MASK) mask_o <= reg_wdata[SRC_N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     reg_rdata <= '0;
        else if (rd_en) reg_rdata <= rd_word;
    end

    // R9: a write elsewhere leaves the mask alone
    a_r9_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == OFS_MASK) |=> $stable(mask_o));
    // R10: read data holds between reads
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(reg_rdata));
    // R9: upper read bits are always zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:SRC_N] == '0);
endmodule

// File: rtl/l2_irq_unit.sv
module l2_irq_unit
    import l2irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ev_cnt_pls,
    input  logic        tag_rd_par_pls,
    input  logic        dat_rd_par_pls,
    input  logic        tag_wr_err_pls,
    input  logic        dat_wr_err_pls,
    input  logic        tag_rd_err_pls,
    input  logic        dat_rd_err_pls,
    input  logic        mem_slverr_pls,
    input  logic        mem_decerr_pls,
    output logic [8:0]  irq_line,
    output logic        irq_any
);
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] raw_q;
    logic [SRC_N-1:0] mask_q;
    logic [SRC_N-1:0] mstat;

    l2irq_src_map u_map (
        .ev_cnt_pls     (ev_cnt_pls),
        .tag_rd_par_pls (tag_rd_par_pls),
        .dat_rd_par_pls (dat_rd_par_pls),
        .tag_wr_err_pls (tag_wr_err_pls),
        .dat_wr_err_pls (dat_wr_err_pls),
        .tag_rd_err_pls (tag_rd_err_pls),
        .dat_rd_err_pls (dat_rd_err_pls),
        .mem_slverr_pls (mem_slverr_pls),
        .mem_decerr_pls (mem_decerr_pls),
        .set_vec        (set_vec)
    );

    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        l2irq_stat_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .raw_o (raw_q[i])
        );
    end

    assign mstat    = raw_q & mask_q;
    assign irq_line = mstat;
    assign irq_any  = |irq_line;

    l2irq_regport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw_i     (raw_q),
        .mstat_i   (mstat),
        .mask_o    (mask_q),
        .clr_o     (clr_vec),
        .reg_rdata (reg_rdata)
    );

    // R6: decode error lands on the slave-error bit
    a_r6_decerr_map: assert property (@(posedge clk) disable iff (!rst_n)
        mem_decerr_pls |=> raw_q[B_SLVERR]);
    // R6: decode-error bit never set by hardware
    a_r6_bit8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_q[B_DECERR]);
    // R8: combined line follows the per-source lines
    a_r8_any: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_line != '0));
    // R3: each pulse sets its raw bit
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cnt_pls |=> raw_q[B_EVCNT]);
endmodule

// File: tb/l2_irq_unit_test.sv
`timescale 1ns/1ps
module l2_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  pls = '0;
    logic        decerr = 1'b0;
    logic [8:0]  irq_line;
    logic        irq_any;

    int total = 0, bad = 0;
    logic [8:0]  m_raw = '0, m_mask = '0;
    logic [31:0] m_rd = '0;

    always #10 clk = ~clk;

    l2_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_cnt_pls(pls[0]), .tag_rd_par_pls(pls[1]), .dat_rd_par_pls(pls[2]),
        .tag_wr_err_pls(pls[3]), .dat_wr_err_pls(pls[4]), .tag_rd_err_pls(pls[5]),
        .dat_rd_err_pls(pls[6]), .mem_slverr_pls(pls[7]), .mem_decerr_pls(decerr),
        .irq_line(irq_line), .irq_any(irq_any)
    );

    function automatic logic [31:0] exp_read(logic [11:0] a);
        case (a)
            12'h214: return {23'd0, m_mask};
            12'h218: return {23'd0, m_raw & m_mask};
            12'h21C: return {23'd0, m_raw};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive, clock, update model, check
    task automatic step(logic sel, logic wr, logic [11:0] a, logic [31:0] d,
                        logic [8:0] p, logic de);
        logic [8:0] setv, clrv;
        reg_sel = sel; reg_wr = wr; reg_addr = a; reg_wdata = d;
        pls = p; decerr = de;
        setv = p; setv[8] = 1'b0; setv[7] = p[7] | de;
        clrv = (sel && wr && a == 12'h220) ? d[8:0] : 9'd0;
        if (sel && !wr) m_rd = exp_read(a);
        @(posedge clk); #1;
        if (sel && wr && a == 12'h214) m_mask = d[8:0];
        m_raw = (m_raw & ~clrv) | setv;
        reg_sel = 1'b0; pls = '0; decerr = 1'b0;
        check("R7 lines", {23'd0, irq_line}, {23'd0, m_raw & m_mask});
        check("R8 any", {31'd0, irq_any}, {31'd0, |(m_raw & m_mask)});
        check("R10 rdata", reg_rdata, m_rd);
    endtask

    task automatic rd(logic [11:0] a);
        step(1'b1, 1'b0, a, 32'd0, 9'd0, 1'b0);
    endtask
    task automatic wr(logic [11:0] a, logic [31:0] d);
        step(1'b1, 1'b1, a, d, 9'd0, 1'b0);
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset lines", {22'd0, irq_any, irq_line}, 32'd0);
        check("R1 reset rdata", reg_rdata, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        rd(12'h21C); check("R1 raw zero", reg_rdata, 32'd0);
        rd(12'h214); check("R1 mask zero", reg_rdata, 32'd0);

        // R2/R7 mask read/write, upper bits dropped
        wr(12'h214, 32'hFFFF_FFFF);
        rd(12'h214); check("R7 mask rw", reg_rdata, 32'h0000_01FF);
        // R3 each source bit position
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 12'd0, 32'd0, 9'(1 << i), 1'b0);
            rd(12'h21C); check("R3 set bit", reg_rdata, 32'(1 << (i + 1)) - 1);
        end
        // R6 decode error goes to bit 7
        wr(12'h220, 32'h1FF);
        step(1'b0, 1'b0, 12'd0, 32'd0, 9'd0, 1'b1);
        rd(12'h21C); check("R6 decerr->bit7", reg_rdata, 32'h80);
        step(1'b0, 1'b0, 12'd0, 32'd0, 9'h100, 1'b0);
        rd(12'h21C); check("R6 bit8 never", reg_rdata, 32'h80);
        // R4 partial clear, zeros ignored
        step(1'b0, 1'b0, 12'd0, 32'd0, 9'h0FF, 1'b0);
        wr(12'h220, 32'h0000_0055);
        rd(12'h21C); check("R4 partial clear", reg_rdata, 32'hAA);
        // R5 set wins
        step(1'b1, 1'b1, 12'h220, 32'h1FF, 9'h002, 1'b0);
        rd(12'h21C); check("R5 set wins", reg_rdata, 32'h02);
        // R9 read-only and unmapped writes ignored, clear reads zero
        wr(12'h21C, 32'h0); wr(12'h218, 32'h0); wr(12'h000, 32'h1FF);
        rd(12'h21C); check("R9 ro write", reg_rdata, 32'h02);
        rd(12'h220); check("R9 clear reads 0", reg_rdata, 32'h0);
        rd(12'h214); check("R9 mask kept", reg_rdata, 32'h1FF);
        // R7 masked view
        wr(12'h214, 32'h0F0);
        step(1'b0, 1'b0, 12'd0, 32'd0, 9'h0FF, 1'b0);
        rd(12'h218); check("R7 masked", reg_rdata, 32'hF0);
        wr(12'h214, 32'h0);
        check("R8 any low", {31'd0, irq_any}, 32'd0);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  k = 3'($urandom_range(0, 7));
            logic [11:0] a;
            logic [8:0]  p = (($urandom_range(0, 3)) == 0) ? 9'($urandom) : 9'd0;
            logic        de = ($urandom_range(0, 7) == 0);
            case (k)
                3'd0: a = 12'h214; 3'd1: a = 12'h218; 3'd2: a = 12'h21C;
                3'd3, 3'd4: a = 12'h220; 3'd5: a = 12'h210;
                default: a = 12'($urandom);
            endcase
            step($urandom_range(0, 3) != 0, 1'($urandom), a, $urandom, p, de);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule